// File: doc/BRIEF.md
# Edge-Latching Banked Interrupt Controller

The block gathers up to 64 interrupt lines into two banks of 32 and presents them to a processor through a small synchronous register port and one interrupt request output. Each bank holds a latched event word, an enable word, a write-one-to-clear acknowledge word and a live view of the raw input lines. A rising edge on an enabled line is captured as an event. The request output goes high while any enabled event is held.

Software reads the event and level words to find what needs service. It treats a source as pending when its event bit or its raw line is high and the source is enabled. It serves the highest-numbered pending source first and then acknowledges it. Turning on an enable bit while its line is already high captures nothing and raises no request. A line that must be noticed in that state is found through the level word.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every enable word and every event word reads zero and `irq` is low.
- R2: Byte addresses inside the 0x40 window: the bank for sources 0-31 starts at 0x20 and the bank for sources 32-63 starts at 0x10. Within a bank, event is at +0x0, enable at +0x4, acknowledge at +0x8 and level at +0xC. Source n is bit n mod 32 of bank n/32.
- R3: The enable word reads back exactly the value last written to it.
- R4: An event bit is set only by a rising edge of its line, meaning the line is high now and was low in the previous clock, and only while its enable bit is 1. A rising edge on a disabled line leaves the event bit clear.
- R5: Setting an enable bit while its line is already high sets no event bit and leaves `irq` low.
- R6: Writing 1 to an acknowledge bit clears the matching event bit. Writing 0 to an acknowledge bit leaves it unchanged.
- R7: When an acknowledge write and a new rising edge hit the same bit in the same cycle, the event bit stays set.
- R8: The level word reads the raw state of that bank's 32 input lines.
- R9: `irq` is the OR over both banks of event AND enable, registered once. It rises one clock after the clock that captures the event.
- R10: The acknowledge word reads zero. Reads from any other address, including addresses whose low two bits are not zero, return zero. Writes to those addresses change nothing.
- R11: `rd_data` carries the addressed word in the clock after `rd_en` is sampled high, and is zero in the clock after `rd_en` is sampled low.
- R12: Clearing an enable bit hides its held event from `irq` but does not discard the event. Enabling the bit again raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 64 | Raw interrupt lines, source n on bit n |
| addr | input | 6 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one clock after the strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
An acknowledge write can land in the same cycle as a new rising edge on the bit it clears. The bench provokes this by first latching an event and dropping the line for a clock. It then drives the acknowledge write and the line's rise on the same falling edge. It judges the outcome by reading the event word back, where the bit must still be set. A second collision puts an enable write in the same cycle as a line that is already high. There the event word must stay clear and `irq` must stay low.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   // word select inside one bank, decoded from address bits [3:2]
   typedef enum logic [1:0] {
      REG_EVENT  = 2'd0,
      REG_ENABLE = 2'd1,
      REG_ACK    = 2'd2,
      REG_LEVEL  = 2'd3
   } reg_sel_e;

   // byte base of bank k inside the window: first bank high, second below it
   function automatic int bank_base(int k);
      return 32 - 16 * k;
   endfunction
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
   import evt_irq_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int NUM_BANKS = 2
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output reg_sel_e             sel
);
   localparam int HI_W = ADDR_W - 4;

   assign sel = reg_sel_e'(addr[3:2]);

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_hit
      localparam int BASE = bank_base(k);
      assign bank_hit[k] = (addr[ADDR_W-1:4] == HI_W'(BASE >> 4)) &&
                           (addr[1:0] == 2'b00);
   end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic         en_wr,
   input  logic         ack_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] evt_q,
   output logic [W-1:0] en_q,
   output logic [W-1:0] prev_q
);
   logic [W-1:0] rise;
   logic [W-1:0] clr;

   assign rise = src & ~prev_q & en_q;
   assign clr  = ack_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         en_q   <= '0;
         evt_q  <= '0;
      end else begin
         prev_q <= src;
         if (en_wr) en_q <= wdata;
         // a fresh edge outranks a clear in the same cycle
         evt_q  <= (evt_q & ~clr) | rise;
      end
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] irq_src,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_en,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        rd_en,
   output logic [DATA_W-1:0]           rd_data,
   output logic                        irq
);
   localparam int NUM_SRC = NUM_BANKS * BANK_W;

   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("NUM_BANKS must be 1 or 2");
   end
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_width
      $error("BANK_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover the 0x40 window");
   end

   logic [NUM_BANKS-1:0] bank_hit;
   reg_sel_e             sel;
   logic [NUM_SRC-1:0]   evt_all;
   logic [NUM_SRC-1:0]   en_all;
   logic [NUM_SRC-1:0]   prev_all;
   logic [DATA_W-1:0]    rd_mux;

   evt_irq_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
      .addr     (addr),
      .bank_hit (bank_hit),
      .sel      (sel)
   );

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      logic en_wr_k;
      logic ack_wr_k;
      assign en_wr_k  = wr_en && bank_hit[k] && (sel == REG_ENABLE);
      assign ack_wr_k = wr_en && bank_hit[k] && (sel == REG_ACK);

      evt_irq_bank #(.W(BANK_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .src    (irq_src[k*BANK_W +: BANK_W]),
         .en_wr  (en_wr_k),
         .ack_wr (ack_wr_k),
         .wdata  (wr_data[BANK_W-1:0]),
         .evt_q  (evt_all[k*BANK_W +: BANK_W]),
         .en_q   (en_all[k*BANK_W +: BANK_W]),
         .prev_q (prev_all[k*BANK_W +: BANK_W])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (bank_hit[k]) begin
            case (sel)
               REG_EVENT:  rd_mux = DATA_W'(evt_all[k*BANK_W +: BANK_W]);
               REG_ENABLE: rd_mux = DATA_W'(en_all[k*BANK_W +: BANK_W]);
               REG_LEVEL:  rd_mux = DATA_W'(irq_src[k*BANK_W +: BANK_W]);
               default:    rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         irq     <= 1'b0;
      end else begin
         rd_data <= rd_en ? rd_mux : '0;
         irq     <= |(evt_all & en_all);
      end
   end
endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_src,
   input logic               wr_en,
   input logic               rd_en,
   input logic [DATA_W-1:0]  rd_data,
   input logic               irq,
   input logic [NUM_SRC-1:0] evt_all,
   input logic [NUM_SRC-1:0] en_all,
   input logic [NUM_SRC-1:0] prev_all
);
   // R4 / R5: a new event bit needs an enabled rising edge in the cycle before
   assert_evt_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_all & ~$past(evt_all) & ~$past(en_all & irq_src & ~prev_all)) == '0));

   // R6: event bits only disappear through a write
   assert_evt_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt_all) & ~evt_all) != '0) |-> $past(wr_en));

   // R3: enable words change only on a write
   assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_all));

   // R9: request rises only after an enabled event was held
   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(evt_all & en_all)));

   // R11: no read strobe, no read data
   assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));
endmodule

bind evt_irq_ctrl evt_irq_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_src  (irq_src),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .irq      (irq),
   .evt_all  (evt_all),
   .en_all   (en_all),
   .prev_all (prev_all)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_src = '0;
   logic [5:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   evt_irq_ctrl u_evt_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [5:0] base_of(int n);
      return (n < 32) ? 6'h20 : 6'h10;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic idle(int c);
      repeat (c) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] pats [4];
      pats[0] = 32'hA5A5_5A5A; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h0000_0001; pats[3] = 32'h8000_0000;

      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(6'h24, v); check("R1 enable bank0", v, 0);
      rd(6'h14, v); check("R1 enable bank1", v, 0);
      rd(6'h20, v); check("R1 event bank0", v, 0);
      rd(6'h10, v); check("R1 event bank1", v, 0);
      // R11 idle read data
      check("R11 idle rd_data", rd_data, 0);

      // R3 enable readback on both banks
      foreach (pats[i]) begin
         wr(6'h24, pats[i]); wr(6'h14, ~pats[i]);
         rd(6'h24, v); check("R3 enable bank0", v, pats[i]);
         rd(6'h14, v); check("R3 enable bank1", v, ~pats[i]);
      end
      wr(6'h24, 0); wr(6'h14, 0);

      // R2 R4 R6 R8 R9: sweep every source
      for (int n = 0; n < 64; n++) begin
         logic [5:0]  b;
         logic [31:0] bit_n;
         b = base_of(n);
         bit_n = 32'd1 << (n % 32);
         wr(b + 6'h4, bit_n);
         @(negedge clk); irq_src[n] = 1'b1;
         @(negedge clk); check($sformatf("R9 irq not yet src%0d", n), {31'd0, irq}, 0);
         @(negedge clk); check($sformatf("R9 irq src%0d", n), {31'd0, irq}, 1);
         rd(b, v);        check($sformatf("R4 R2 event src%0d", n), v, bit_n);
         rd(b + 6'hC, v); check($sformatf("R8 level src%0d", n), v, bit_n);
         irq_src[n] = 1'b0;
         wr(b + 6'h8, bit_n);
         idle(1);
         check($sformatf("R6 irq cleared src%0d", n), {31'd0, irq}, 0);
         rd(b, v); check($sformatf("R6 event cleared src%0d", n), v, 0);
         wr(b + 6'h4, 0);
      end

      // R4 negative: rising edge on a disabled line
      @(negedge clk); irq_src[40] = 1'b1;
      idle(3);
      rd(6'h10, v); check("R4 disabled edge ignored", v, 0);
      check("R4 disabled irq", {31'd0, irq}, 0);
      irq_src[40] = 1'b0;

      // R8 level pattern
      @(negedge clk); irq_src = 64'h1234_5678_9ABC_DEF0;
      rd(6'h2C, v); check("R8 level bank0", v, 32'h9ABC_DEF0);
      rd(6'h1C, v); check("R8 level bank1", v, 32'h1234_5678);
      @(negedge clk); irq_src = '0;
      idle(2);

      // R5 enable while already high
      @(negedge clk); irq_src[5] = 1'b1;
      idle(2);
      wr(6'h24, 32'h20);
      idle(3);
      check("R5 irq stays low", {31'd0, irq}, 0);
      rd(6'h20, v); check("R5 no event", v, 0);
      rd(6'h2C, v); check("R5 level visible", v, 32'h20);
      irq_src[5] = 1'b0;
      idle(2);
      @(negedge clk); irq_src[5] = 1'b1;
      idle(3);
      rd(6'h20, v); check("R4 edge after re-arm", v, 32'h20);

      // R6 acknowledge with zeros
      wr(6'h28, 32'h0);
      rd(6'h20, v); check("R6 zero ack no effect", v, 32'h20);

      // R10 undefined / acknowledge reads and ignored writes
      rd(6'h28, v); check("R10 ack reads zero", v, 0);
      rd(6'h00, v); check("R10 addr 0x00", v, 0);
      rd(6'h30, v); check("R10 addr 0x30", v, 0);
      rd(6'h3C, v); check("R10 addr 0x3C", v, 0);
      rd(6'h21, v); check("R10 misaligned read", v, 0);
      wr(6'h25, 32'hFFFF_FFFF);
      wr(6'h04, 32'hFFFF_FFFF);
      wr(6'h29, 32'hFFFF_FFFF);
      rd(6'h24, v); check("R10 writes ignored enable", v, 32'h20);
      rd(6'h20, v); check("R10 writes ignored event", v, 32'h20);

      // R12 mask hides but keeps the event
      wr(6'h24, 0);
      idle(1);
      check("R12 irq hidden", {31'd0, irq}, 0);
      rd(6'h20, v); check("R12 event kept", v, 32'h20);
      wr(6'h24, 32'h20);
      idle(1);
      check("R12 irq returns", {31'd0, irq}, 1);

      // R7 acknowledge and new edge in one cycle
      irq_src[5] = 1'b0;
      idle(2);
      @(negedge clk);
      addr = 6'h28; wr_data = 32'h20; wr_en = 1'b1; irq_src[5] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      rd(6'h20, v); check("R7 edge beats ack", v, 32'h20);
      irq_src[5] = 1'b0;
      wr(6'h28, 32'h20);
      rd(6'h20, v); check("R6 final clear", v, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule